// File: doc/BRIEF.md
# Repeating Pulse Train Generator with Gated Carrier

The block plays back a list of durations held in a small internal memory as a waveform of alternating high and low intervals. Entry 0 gives the length of the first high interval, entry 1 the first low interval, and so on. Every duration is counted in ticks, and a programmable prescaler sets the tick. A zero entry, or the end of the memory, ends one pass over the list. The train repeats for a set number of passes, or without end until a cancel request arrives.

A carrier output can be enabled. When it is, the carrier runs at a programmable period and duty during each high interval. It is held low at all other times. Software writes the durations through a simple load port, then sets the configuration inputs and pulses start. A busy flag covers the whole train. A one-cycle done pulse marks its end.

A tick of 1 µs at a 200 MHz clock needs a divider value of 199. The prescaler value, the pass count and the end-check mode are captured when a start is accepted. The carrier enable, period and duty inputs are used directly and are not captured.

Top module: `pulse_train_gen`

## Requirements
- R1: Entry j is output for `entry*(tick_div_i+1)` clock cycles. Even j (0, 2, ...) drive `pulse_o` high and odd j drive it low. The first interval starts in the cycle after the accepted start edge.
- R2: A pass ends at the first zero entry, or after entry DEPTH-1 when no zero is present. Entries past a zero are never played.
- R3: `reps_i` = N > 0 plays exactly N passes back to back. Each pass restarts at entry 0 with `pulse_o` high.
- R4: `reps_i` = 0 repeats the pass with no limit.
- R5: A `cancel_i` pulse during a train lets the current pass complete and then stops the train.
- R6: `busy_o` is high from the cycle after an accepted start through the last cycle of the last interval. `done_o` is high for exactly the single cycle that follows. A start while entry 0 is zero asserts `done_o` in the next cycle, leaves `busy_o` low and drives `pulse_o` low.
- R7: After reset, `pulse_o` is low. After a train it holds the level of its last interval: high for an odd count of nonzero entries and low for an even count. When `check_i` was high at start, it is forced low instead. `pulse_o` keeps that level while idle.
- R8: With `car_en_i` high, in the k-th cycle (k from 0) of a continuous high stretch, `carrier_o` = ((k mod (car_period_i+1)) < car_duty_i). `carrier_o` is 0 during low intervals, while idle, and when `car_en_i` is low.
- R9: A start request while busy is ignored. Changing `reps_i` during a train has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Write strobe for the duration memory |
| load_addr_i | input | AW | Entry index to write |
| load_data_i | input | DUR_W | Duration in ticks (0 terminates) |
| start_i | input | 1 | Start request, accepted only when idle |
| cancel_i | input | 1 | Stop after the current pass |
| reps_i | input | REP_W | Pass count, 0 = continuous |
| check_i | input | 1 | Force final level low |
| tick_div_i | input | DIV_W | Tick length minus one, in clock cycles |
| car_en_i | input | 1 | Carrier enable |
| car_period_i | input | CAR_W | Carrier period minus one, in clock cycles |
| car_duty_i | input | CAR_W | Carrier active cycles per period |
| pulse_o | output | 1 | Pulse train output |
| carrier_o | output | 1 | Gated carrier output |
| busy_o | output | 1 | Train in progress |
| done_o | output | 1 | One-cycle end-of-train pulse |

## Verification
From the entry list, the divider and the pass count, the bench computes a per-cycle reference for `pulse_o` and `carrier_o`. Cycle 0 is the first cycle after the edge that takes the start. Level changes fall on multiples of `entry*(div+1)` from there. `busy_o` must drop and `done_o` must rise exactly `exp_len` cycles after cycle 0, with `done_o` low again one cycle later. An empty train's done is due in cycle 0. Every sample is taken at the falling edge. Cancel and repeated starts are driven at chosen cycle indices inside the same loop.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_RUN  = 1'b1
  } ps_e;
endpackage

// File: rtl/ptg_mem.sv
module ptg_mem #(
  parameter int DEPTH = 16,
  parameter int DUR_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DUR_W-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DUR_W-1:0] rd_data_o,
  output logic [DUR_W-1:0] first_o
);
  logic [DUR_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign first_o   = mem_q[0];
endmodule

// File: rtl/ptg_tick.sv
module ptg_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R1: with a divider above zero, ticks never come back to back
  a_r1_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (div_i != '0) |=> !tick_o);
endmodule

// File: rtl/ptg_carrier.sv
module ptg_carrier #(
  parameter int CAR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  logic             en_i,
  input  logic [CAR_W-1:0] period_i,
  input  logic [CAR_W-1:0] duty_i,
  output logic             car_o
);
  logic [CAR_W-1:0] cnt_q;

  // phase restarts whenever the gate is closed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!gate_i)          cnt_q <= '0;
    else if (cnt_q >= period_i) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign car_o = en_i && gate_i && (cnt_q < duty_i);

  // R8: every burst opens at phase zero
  a_r8_burst_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_i) |-> cnt_q == '0);
endmodule

// File: rtl/ptg_seq.sv
module ptg_seq
  import ptg_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DUR_W = 16,
  parameter int REP_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cancel_i,
  input  logic [REP_W-1:0] reps_i,
  input  logic             check_i,
  input  logic             tick_i,
  input  logic [DUR_W-1:0] first_i,
  input  logic [DUR_W-1:0] rd_data_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             lvl_o
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  ps_e              state_q;
  logic [AW-1:0]    idx_q;
  logic [DUR_W-1:0] cnt_q;
  logic             lvl_q, done_q, check_q, cancel_q, forever_q;
  logic [REP_W-1:0] left_q;

  logic seg_end, next_zero, more_pass, busy;

  assign busy      = (state_q == PS_RUN);
  assign rd_addr_o = idx_q + 1'b1;
  assign seg_end   = busy && tick_i && (cnt_q == DUR_W'(1));
  assign next_zero = (idx_q == LAST_IDX) || (rd_data_i == '0);
  assign more_pass = !(cancel_q || cancel_i) && (forever_q || (left_q > REP_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PS_IDLE;
      idx_q     <= '0;
      cnt_q     <= '0;
      lvl_q     <= 1'b0;
      done_q    <= 1'b0;
      check_q   <= 1'b0;
      cancel_q  <= 1'b0;
      forever_q <= 1'b0;
      left_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        PS_IDLE: begin
          if (start_i) begin
            if (first_i == '0) begin
              done_q <= 1'b1;
              lvl_q  <= 1'b0;
            end else begin
              state_q   <= PS_RUN;
              idx_q     <= '0;
              cnt_q     <= first_i;
              lvl_q     <= 1'b1;
              left_q    <= reps_i;
              forever_q <= (reps_i == '0);
              check_q   <= check_i;
              cancel_q  <= 1'b0;
            end
          end
        end
        PS_RUN: begin
          if (cancel_i) cancel_q <= 1'b1;
          if (seg_end) begin
            if (!next_zero) begin
              idx_q <= rd_addr_o;
              cnt_q <= rd_data_i;
              lvl_q <= ~lvl_q;
            end else if (more_pass) begin
              idx_q <= '0;
              cnt_q <= first_i;
              lvl_q <= 1'b1;
              if (!forever_q) left_q <= left_q - 1'b1;
            end else begin
              state_q <= PS_IDLE;
              done_q  <= 1'b1;
              lvl_q   <= check_q ? 1'b0 : lvl_q;
            end
          end else if (tick_i) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  assign busy_o = busy;
  assign done_o = done_q;
  assign lvl_o  = lvl_q;

  // R6: the end of a train always comes with done
  a_r6_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done_q);
  // R1: a running interval never has a zero count
  a_r1_cnt_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> cnt_q != '0);
  // R9: a start while running leaves the position untouched
  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && start_i && !tick_i |=> $stable(cnt_q) && $stable(idx_q) && $stable(left_q));
  // R7: idle output holds until a start
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !start_i |=> $stable(lvl_q));
  // R3: an accepted nonempty start opens with a high interval
  a_r3_open_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && start_i && (first_i != '0) |=> busy && lvl_q);
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
  parameter int DEPTH = 16,
  parameter int DUR_W = 16,
  parameter int REP_W = 8,
  parameter int DIV_W = 8,
  parameter int CAR_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic [AW-1:0]    load_addr_i,
  input  logic [DUR_W-1:0] load_data_i,
  input  logic             start_i,
  input  logic             cancel_i,
  input  logic [REP_W-1:0] reps_i,
  input  logic             check_i,
  input  logic [DIV_W-1:0] tick_div_i,
  input  logic             car_en_i,
  input  logic [CAR_W-1:0] car_period_i,
  input  logic [CAR_W-1:0] car_duty_i,
  output logic             pulse_o,
  output logic             carrier_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [DUR_W-1:0] rd_data, first;
  logic [AW-1:0]    rd_addr;
  logic [DIV_W-1:0] div_q;
  logic             tick, busy, lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (start_i && !busy) div_q <= tick_div_i;
  end

  ptg_mem #(.DEPTH(DEPTH), .DUR_W(DUR_W)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (load_en_i),
    .wr_addr_i (load_addr_i),
    .wr_data_i (load_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .first_o   (first)
  );

  ptg_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div_q),
    .tick_o (tick)
  );

  ptg_seq #(.DEPTH(DEPTH), .DUR_W(DUR_W), .REP_W(REP_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cancel_i  (cancel_i),
    .reps_i    (reps_i),
    .check_i   (check_i),
    .tick_i    (tick),
    .first_i   (first),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .busy_o    (busy),
    .done_o    (done_o),
    .lvl_o     (lvl)
  );

  ptg_carrier #(.CAR_W(CAR_W)) u_car (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gate_i   (busy && lvl),
    .en_i     (car_en_i),
    .period_i (car_period_i),
    .duty_i   (car_duty_i),
    .car_o    (carrier_o)
  );

  assign pulse_o = lvl;
  assign busy_o  = busy;
endmodule

// File: tb/pulse_train_gen_test.sv
`timescale 1ns/1ps
module pulse_train_gen_test;
  localparam int DEPTH = 16;
  localparam int DUR_W = 16;
  localparam int REP_W = 8;
  localparam int DIV_W = 8;
  localparam int CAR_W = 8;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [DUR_W-1:0] load_data = '0;
  logic start = 1'b0, cancel = 1'b0, check = 1'b0, car_en = 1'b0;
  logic [REP_W-1:0] reps = '0;
  logic [DIV_W-1:0] tdiv = '0;
  logic [CAR_W-1:0] cper = '0, cduty = '0;
  logic pulse, carrier, busy, done;

  always #2.5 clk = ~clk;

  pulse_train_gen #(.DEPTH(DEPTH), .DUR_W(DUR_W), .REP_W(REP_W), .DIV_W(DIV_W), .CAR_W(CAR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .load_addr_i(load_addr),
    .load_data_i(load_data), .start_i(start), .cancel_i(cancel), .reps_i(reps),
    .check_i(check), .tick_div_i(tdiv), .car_en_i(car_en), .car_period_i(cper),
    .car_duty_i(cduty), .pulse_o(pulse), .carrier_o(carrier), .busy_o(busy), .done_o(done)
  );

  int n_tests = 0, n_fail = 0;
  int ent [DEPTH];
  logic exp_p [0:4095];
  logic exp_c [0:4095];
  int exp_len;
  logic exp_final;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic load_mem();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = AW'(i); load_data = DUR_W'(ent[i]);
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // reference waveform built from R1/R2/R3/R7/R8
  task automatic build(input int passes, input int dv, input bit chk_md, input bit cen, input int per, input int dty);
    int n, idx, run;
    n = 0;
    while (n < DEPTH && ent[n] != 0) n++;
    idx = 0; run = 0;
    for (int p = 0; p < passes; p++)
      for (int j = 0; j < n; j++)
        for (int c = 0; c < ent[j] * (dv + 1); c++) begin
          exp_p[idx] = (j % 2 == 0);
          if (j % 2 == 0) begin
            exp_c[idx] = cen && ((run % (per + 1)) < dty);
            run++;
          end else begin
            exp_c[idx] = 1'b0;
            run = 0;
          end
          idx++;
        end
    exp_len = idx;
    exp_final = (n == 0) ? 1'b0 : (chk_md ? 1'b0 : ((n - 1) % 2 == 0));
  endtask

  task automatic run_check(input string req, input int restart_at, input int cancel_at);
    int bad_p, bad_c, bad_b, bad_d;
    bad_p = 0; bad_c = 0; bad_b = 0; bad_d = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < exp_len; c++) begin
      if (pulse !== exp_p[c]) bad_p++;
      if (carrier !== exp_c[c]) bad_c++;
      if (busy !== 1'b1) bad_b++;
      if (done !== 1'b0) bad_d++;
      start  = (c == restart_at);
      cancel = (c == cancel_at);
      if (c == restart_at) reps = REP_W'(1);
      @(negedge clk);
    end
    start = 1'b0; cancel = 1'b0;
    chk(bad_p == 0, req, "R1 pulse mismatches", bad_p, 0);
    chk(bad_c == 0, req, "R8 carrier mismatches", bad_c, 0);
    chk(bad_b == 0, req, "R6 busy low mid-train", bad_b, 0);
    chk(bad_d == 0, req, "R6 done early", bad_d, 0);
    chk(busy == 1'b0 && done == 1'b1, req, "R6 end busy/done", {busy, done}, 1);
    chk(pulse == exp_final, req, "R7 final level", pulse, exp_final);
    chk(carrier == 1'b0, req, "R8 carrier idle", carrier, 0);
    @(negedge clk);
    chk(done == 1'b0, req, "R6 done single cycle", done, 0);
    chk(pulse == exp_final, req, "R7 idle hold", pulse, exp_final);
  endtask

  initial begin
    #(5.0 * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(pulse == 0 && carrier == 0 && busy == 0 && done == 0, "R7", "reset outputs",
        {pulse, carrier, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: odd count, no check -> left high; R1 basic timing, div 2
    ent = '{3, 1, 2, 0, 5, 5, 5, 5, 5, 5, 5, 5, 5, 5, 5, 5};
    load_mem();
    tdiv = 2; reps = 1; check = 0; car_en = 0;
    build(1, 2, 0, 0, 0, 0);
    run_check("R7_odd_high", -1, -1);

    // R7: same train with check forces low; R3 two passes
    reps = 2; check = 1;
    build(2, 2, 1, 0, 0, 0);
    run_check("R3_two_pass", -1, -1);

    // R2: no zero anywhere, memory end terminates
    for (int i = 0; i < DEPTH; i++) ent[i] = 1 + (i % 3);
    load_mem();
    tdiv = 0; reps = 1; check = 0;
    build(1, 0, 0, 0, 0, 0);
    run_check("R2_mem_end", -1, -1);

    // R8: carrier gated, period 3, duty 2
    ent = '{6, 2, 4, 3, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1};
    load_mem();
    tdiv = 1; reps = 2; car_en = 1; cper = 3; cduty = 2;
    build(2, 1, 0, 1, 3, 2);
    run_check("R8_carrier", -1, -1);

    // R4/R5: continuous, cancel within second pass
    reps = 0; car_en = 0;
    build(2, 1, 0, 0, 0, 0);
    run_check("R5_cancel_R4", -1, exp_len / 2 + 1);

    // R9: start and reps change while busy are ignored
    reps = 3;
    build(3, 1, 0, 0, 0, 0);
    run_check("R9_restart", 5, -1);

    // R6: empty train
    ent[0] = 0;
    load_mem();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1 && busy == 0 && pulse == 0, "R6", "empty train", {done, busy, pulse}, 4);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R6", "empty train after", {done, busy}, 0);

    // random trains
    for (int t = 0; t < 8; t++) begin
      int n, dv, rp, per, dty;
      bit cm, ce;
      n = 1 + ($urandom % (DEPTH - 1));
      for (int i = 0; i < DEPTH; i++) ent[i] = 1 + ($urandom % 5);
      ent[n] = 0;
      dv = $urandom % 4; rp = 1 + ($urandom % 3);
      cm = 1'($urandom % 2); ce = 1'($urandom % 2);
      per = 1 + ($urandom % 4); dty = $urandom % (per + 2);
      load_mem();
      tdiv = DIV_W'(dv); reps = REP_W'(rp); check = cm; car_en = ce;
      cper = CAR_W'(per); cduty = CAR_W'(dty);
      build(rp, dv, cm, ce, per, dty);
      run_check("R1_R2_R3_rand", -1, -1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule